// File: doc/BRIEF.md
# Write-Only Two-Wire Clock Configuration Slave

This block is a receive-only slave on a two-wire serial bus (SCL clock, SDA open-drain data). It loads a bank of eight 8-bit clock-control registers from a host. Both bus lines are sampled in the system clock domain. A transfer opens with a start condition and a write address byte for device address 0x69. Two preamble bytes follow; their values are ignored. Every byte after them is stored in sequence, beginning at register 0. Nothing is ever sent back to the host apart from acknowledge bits.

The block has no sub-addressing. To change a given register, the host resends every register below it in the same transfer. While the active-low sleep input is low, the interface takes no part in bus traffic and the register contents stay as they are. The register outputs drive the clock-tree controls directly.

Top module: `cfgs_twowire_slave`

## Requirements
- R1: After reset, register 0 reads 0x0C (bits 3 and 2 set, which selects the higher rate on both selectable outputs). Registers 1 to 5 read 0xFF (every per-output enable set). Registers 6 and 7 read 0x00.
- R2: A stop condition (SDA rising while SCL is high) ends the transfer. Bytes clocked after a stop without a new start get no acknowledge and change no register.
- R3: Bytes are received MSB first. The first byte after a start equal to 0xD2 (address 0x69 with write direction bit 0) is acknowledged: `sda_pull_o` is high during the ninth SCL high phase.
- R4: After any other first byte, no acknowledge is given and no register changes until the next start.
- R5: A read request (first byte 0xD3) is never acknowledged and changes no register.
- R6: The two bytes that follow a matched address are acknowledged and then discarded; no register changes because of them.
- R7: The third and later bytes after the address write registers 0, 1, 2, … in order. Each is acknowledged. Registers not reached keep their values. At most one register is written per cycle.
- R8: Data bytes beyond register 7 are still acknowledged but are not stored.
- R9: While `sleep_n` is low, bus activity is ignored: no acknowledge is given and no register changes. Contents survive sleep.
- R10: A repeated start (a start with no stop before it) begins a new transfer, and the data that follows again fills from register 0.
- R11: `sda_pull_o` only asserts while SCL is low and never during the eight data bits of a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| sleep_n | input | 1 | Active-low sleep; the bus interface is idle while low |
| scl_i | input | 1 | Sampled SCL bus line |
| sda_i | input | 1 | Sampled SDA bus line (wired value) |
| sda_pull_o | output | 1 | Drives SDA low when high (open-drain enable) |
| cfg_regs_o | output | 64 | Register bank; register k at bits [8k+7:8k] |

## Verification
The assertions assume the host obeys bus timing. SDA changes only while SCL is low, except when the host deliberately forms a start or stop. Every SCL level lasts several system clocks, so the synchroniser never merges an SDA change with an SCL edge. The stimulus respects this by building every bit from quarter-periods of five system clocks. The host releases SDA in the ninth bit, and the bench wires SDA as the AND of the host's drive and the inverted pull enable. Random transfers use random addresses, lengths and payloads, with and without repeated starts. They sit beside directed cases for overflow, mismatch, read, sleep and bytes clocked after a stop.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

    parameter int unsigned NREG     = 8;
    parameter int unsigned DW       = 8;
    parameter int unsigned PREAMBLE = 2;
    parameter logic [6:0]  DEV_ADDR = 7'h69;

    localparam int unsigned IW     = $clog2(NREG);
    localparam int unsigned BMAX   = 1 + PREAMBLE + NREG;
    localparam int unsigned BIW    = $clog2(BMAX + 1);
    localparam int unsigned FIRST  = 1 + PREAMBLE;
    localparam logic [DW-1:0] WR_BYTE = {DEV_ADDR, 1'b0};

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_BITS,
        FS_ACKPEND,
        FS_ACK,
        FS_SKIP
    } fsm_t;

    typedef struct packed {
        logic scl_hi;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic [DW-1:0] reg_reset(input int unsigned idx);
        logic [DW-1:0] v;
        v = '0;
        if (idx == 0)
            v = 8'h0C;
        else if (idx >= 1 && idx <= 5)
            v = '1;
        return v;
    endfunction

endpackage

// File: rtl/cfgs_line_sync.sv
module cfgs_line_sync
    import cfgs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic [1:0] scl_sy;
    logic [1:0] sda_sy;
    logic       scl_q;
    logic       sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sy <= 2'b11;
            sda_sy <= 2'b11;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[0], scl_i};
            sda_sy <= {sda_sy[0], sda_i};
            scl_q  <= scl_sy[1];
            sda_q  <= sda_sy[1];
        end
    end

    always_comb begin
        ev.scl_hi   = scl_sy[1];
        ev.sda      = sda_sy[1];
        ev.scl_rise = scl_sy[1] & ~scl_q;
        ev.scl_fall = ~scl_sy[1] & scl_q;
        ev.start    = scl_sy[1] & scl_q & sda_q & ~sda_sy[1];
        ev.stop     = scl_sy[1] & scl_q & ~sda_q & sda_sy[1];
    end

endmodule

// File: rtl/cfgs_rx_fsm.sv
module cfgs_rx_fsm
    import cfgs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sleep_n,
    input  line_ev_t      ev,
    output logic          sda_pull,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [DW-1:0] wr_data
);
    fsm_t           state;
    logic [2:0]     bitcnt;
    logic [DW-1:0]  shreg;
    logic [BIW-1:0] byte_idx;
    logic [BIW-1:0] data_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= FS_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            byte_idx <= '0;
            sda_pull <= 1'b0;
        end else if (!sleep_n) begin
            state    <= FS_IDLE;
            sda_pull <= 1'b0;
        end else if (ev.start) begin
            state    <= FS_BITS;
            bitcnt   <= '0;
            byte_idx <= '0;
            sda_pull <= 1'b0;
        end else if (ev.stop) begin
            state    <= FS_IDLE;
            sda_pull <= 1'b0;
        end else begin
            unique case (state)
                FS_BITS: begin
                    if (ev.scl_rise) begin
                        shreg  <= {shreg[DW-2:0], ev.sda};
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7)
                            state <= FS_ACKPEND;
                    end
                end
                FS_ACKPEND: begin
                    if (ev.scl_fall) begin
                        if (byte_idx == '0 && shreg != WR_BYTE) begin
                            state <= FS_SKIP;
                        end else begin
                            state    <= FS_ACK;
                            sda_pull <= 1'b1;
                        end
                    end
                end
                FS_ACK: begin
                    if (ev.scl_fall) begin
                        sda_pull <= 1'b0;
                        state    <= FS_BITS;
                        bitcnt   <= '0;
                        if (byte_idx != BIW'(BMAX))
                            byte_idx <= byte_idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        data_off = byte_idx - BIW'(FIRST);
        wr_idx   = data_off[IW-1:0];
        wr_data  = {shreg[DW-2:0], ev.sda};
        wr_en    = sleep_n && !ev.start && !ev.stop
                && state == FS_BITS && ev.scl_rise && bitcnt == 3'd7
                && byte_idx >= BIW'(FIRST) && byte_idx < BIW'(BMAX);
    end

    AST_PULL_ON_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !ev.scl_hi); // R11
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && sleep_n) |=> !sda_pull); // R2
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state == FS_SKIP) |-> (!sda_pull && !wr_en)); // R4
    AST_NO_PULL_BITS: assert property (@(posedge clk) disable iff (rst)
        (state == FS_BITS) |-> !sda_pull); // R11

endmodule

// File: rtl/cfgs_reg_bank.sv
module cfgs_reg_bank
    import cfgs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_idx,
    input  logic [DW-1:0]      wr_data,
    output logic [NREG*DW-1:0] regs
);
    logic [NREG-1:0] sel;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        assign sel[g] = wr_en && (wr_idx == IW'(g));
        always_ff @(posedge clk) begin
            if (rst)
                regs[g*DW +: DW] <= reg_reset(g);
            else if (sel[g])
                regs[g*DW +: DW] <= wr_data;
        end
    end

    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel)); // R7

endmodule

// File: rtl/cfgs_twowire_slave.sv
module cfgs_twowire_slave
    import cfgs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sleep_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    output logic [NREG*DW-1:0] cfg_regs_o
);
    line_ev_t      ev;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [DW-1:0] wr_data;

    cfgs_line_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    cfgs_rx_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .sleep_n  (sleep_n),
        .ev       (ev),
        .sda_pull (sda_pull_o),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data)
    );

    cfgs_reg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .regs    (cfg_regs_o)
    );

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sleep_n |=> !sda_pull_o); // R9
    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sleep_n |=> $stable(cfg_regs_o)); // R9

endmodule

// File: tb/cfgs_twowire_slave_test.sv
module cfgs_twowire_slave_test;
    localparam int Q = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sleep_n = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_pull_o;
    logic [63:0] cfg_regs_o;
    wire         sda_w = sda_m & ~sda_pull_o;

    int n_chk = 0;
    int n_bad = 0;
    int pull_err = 0;
    bit done = 0;

    logic [7:0] exp_r  [8];
    logic [7:0] tx_buf [16];

    always #2 clk = ~clk;

    cfgs_twowire_slave uut (
        .clk        (clk),
        .rst        (rst),
        .sleep_n    (sleep_n),
        .scl_i      (scl_m),
        .sda_i      (sda_w),
        .sda_pull_o (sda_pull_o),
        .cfg_regs_o (cfg_regs_o)
    );

    function automatic logic [7:0] rst_val(input int i);
        if (i == 0) return 8'h0C;
        if (i <= 5) return 8'hFF;
        return 8'h00;
    endfunction

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
        end
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < 8; i++)
            chk(cfg_regs_o[i*8 +: 8] === exp_r[i], req, $sformatf("reg%0d", i),
                cfg_regs_o[i*8 +: 8], exp_r[i]);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q();
            scl_m = 1'b1; wait_q();
            if (sda_pull_o) pull_err++;
            wait_q();
            scl_m = 1'b0; wait_q();
        end
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        ack = sda_pull_o;
        wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    // addr, then n bytes of tx_buf (first two are preamble); model expectation
    task automatic xfer(input logic [7:0] addr, input int n, input string req,
                        input bit do_stop);
        bit a;
        bit hit;
        hit = (addr == 8'hD2) && sleep_n;
        bus_start();
        send_byte(addr, a);
        chk(a == hit, req, "addr ack", 8'(a), 8'(hit));
        for (int k = 0; k < n; k++) begin
            send_byte(tx_buf[k], a);
            chk(a == hit, req, $sformatf("byte%0d ack", k), 8'(a), 8'(hit));
            if (hit && k >= 2 && k - 2 < 8) exp_r[k-2] = tx_buf[k];
        end
        if (do_stop) bus_stop();
    endtask

    initial begin
        bit a;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 8; i++) exp_r[i] = rst_val(i);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check_regs("R1");

        // R3 / R7: full write of all registers
        for (int k = 0; k < 10; k++) tx_buf[k] = 8'(8'h10 * k + 8'h3);
        xfer(8'hD2, 10, "R7", 1);
        check_regs("R7");

        // R6: preamble only, nothing stored
        tx_buf[0] = 8'hAA; tx_buf[1] = 8'h55;
        xfer(8'hD2, 2, "R6", 1);
        check_regs("R6");

        // R7 partial: three data bytes
        tx_buf[0] = 8'h00; tx_buf[1] = 8'h00;
        tx_buf[2] = 8'hC1; tx_buf[3] = 8'hC2; tx_buf[4] = 8'hC3;
        xfer(8'hD2, 5, "R7", 1);
        check_regs("R7");

        // R8: overflow past register 7
        for (int k = 0; k < 13; k++) tx_buf[k] = 8'(8'hE0 + k);
        xfer(8'hD2, 13, "R8", 1);
        check_regs("R8");

        // R4: wrong address, bytes ignored
        for (int k = 0; k < 6; k++) tx_buf[k] = 8'h5A;
        xfer(8'hA4, 6, "R4", 1);
        check_regs("R4");

        // R5: read request
        xfer(8'hD3, 6, "R5", 1);
        check_regs("R5");

        // R10: repeated start restarts at register 0
        for (int k = 0; k < 6; k++) tx_buf[k] = 8'(8'h70 + k);
        xfer(8'hD2, 6, "R10", 0);
        for (int k = 0; k < 4; k++) tx_buf[k] = 8'(8'h90 + k);
        xfer(8'hD2, 4, "R10", 1);
        check_regs("R10");

        // R2: bytes after stop without start
        send_byte(8'hD2, a);
        chk(a == 1'b0, "R2", "post-stop ack", 8'(a), 8'h00);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_byte(8'h3C, a);
        chk(a == 1'b0, "R2", "post-stop data ack", 8'(a), 8'h00);
        check_regs("R2");

        // R9: sleep ignores bus and keeps contents
        sleep_n = 1'b0;
        for (int k = 0; k < 5; k++) tx_buf[k] = 8'h11;
        xfer(8'hD2, 5, "R9", 1);
        check_regs("R9");
        sleep_n = 1'b1;
        wait_q();
        check_regs("R9");

        // random transfers
        for (int t = 0; t < 24; t++) begin
            logic [7:0] ad;
            int n;
            ad = ($urandom % 4 != 0) ? 8'hD2 : 8'($urandom);
            n = $urandom % 12;
            for (int k = 0; k < 16; k++) tx_buf[k] = 8'($urandom);
            xfer(ad, n, "R7", ($urandom % 3) != 0);
            check_regs("R7");
        end
        bus_stop();

        chk(pull_err == 0, "R11", "pull during data bits", 8'(pull_err), 8'h00);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule